// File: doc/BRIEF.md
# Two-Step Staged Readback Path

This block sits between a host accumulator and a channel. It lets the host read four channel-side values: the byte count, a combined status-and-address word, the input tags and the local memory address word. A read never reaches the accumulator on its first issue. The first issue copies the live value into a single intermediate holding register. A second issue of the same read, in the very next cycle, then moves the holding register to the accumulator.

Three write functions load the holding register straight from the accumulator. A read of the matching kind, issued in the cycle right after the write, returns that loaded value at once. This gives the host a loopback test of the accumulator fanout, the holding register and the return path. The output-tag write also updates the output tags register that drives the channel.

The function code is sampled on each rising clock edge while `fn_valid` is high. The encoding is:

| Code | Function |
|------|----------|
| 0 | none |
| 1 | read count |
| 2 | read status |
| 3 | read tags |
| 4 | read local memory address |
| 5 | write count |
| 6 | write device address |
| 7 | write output tags |

Top module: `staged_readback`

## Requirements
- R1: After reset, `acc_out` is 0, `acc_valid` is 0 and `otags` is 0.
- R2: A read count (code 1) issued in two consecutive cycles delivers, one cycle after the second issue, the `live_count` value sampled at the first issue. `acc_valid` is high for that one cycle, and the count is zero-extended into `acc_out`.
- R3: A read status (code 2) issued twice consecutively delivers the status sampled at the first issue in `acc_out` bits 7:0 and the address in bits 15:8.
- R4: A read tags (code 3) issued twice consecutively delivers the `live_itags` sampled at the first issue, zero-extended.
- R5: A read local memory address (code 4) issued twice consecutively delivers the `live_lma` sampled at the first issue.
- R6: Any cycle with `fn_valid` low, or with code 0, breaks a pair. A read after such a cycle acts as a first issue: it leaves `acc_valid` low and `acc_out` unchanged.
- R7: A read that follows a different read acts as a first issue and replaces the holding register with its own live value.
- R8: Issues pair up. The cycle that delivers also disarms the path, so a third consecutive issue captures afresh, and a fourth delivers the value captured at the third.
- R9: A write count (code 5) followed at once by a read count delivers `acc_in[CNT_W-1:0]` from the write cycle.
- R10: A write device address (code 6) followed at once by a read status delivers the full `acc_in` from the write cycle.
- R11: A write output tags (code 7) sets `otags` to `acc_in[TAG_W-1:0]` from the next cycle on. A read tags that follows at once delivers that same value.
- R12: `acc_out` holds the last delivered value whenever no delivery occurs. `otags` changes only on a write output tags.
- R13: A write followed by a read that is not its pair acts as a first issue of that read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fn_valid | input | 1 | A function is issued this cycle |
| fn_code | input | 3 | Function code, see the encoding table |
| acc_in | input | ACC_W | Accumulator value used by the write functions |
| live_count | input | CNT_W | Live byte count from the channel |
| live_status | input | ST_W | Live status bits |
| live_addr | input | AD_W | Live device address bits |
| live_itags | input | TAG_W | Live input tags |
| live_lma | input | ACC_W | Live local memory address word |
| acc_out | output | ACC_W | Value delivered to the accumulator |
| acc_valid | output | 1 | One-cycle pulse marking a delivery |
| otags | output | TAG_W | Output tags register |

## Verification
The bench keeps the default 16-bit accumulator and count, the 8-bit status and address fields, and builds the block with `TAG_W` set to 10. This makes the zero-extension and masking of the tags visible in the upper accumulator bits. With only eight function codes, the bench sweeps every ordered pair of a preceding function and a following read. The live inputs change between the two issues, so a delivery must show the value from the first issue. Separate runs cover four back-to-back reads, a gap between issues, and the reset state.

// File: rtl/staged_readback.sv
module staged_readback #(
  parameter int ACC_W = 16,
  parameter int CNT_W = 16,
  parameter int ST_W  = 8,
  parameter int AD_W  = 8,
  parameter int TAG_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fn_valid,
  input  logic [2:0]       fn_code,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [CNT_W-1:0] live_count,
  input  logic [ST_W-1:0]  live_status,
  input  logic [AD_W-1:0]  live_addr,
  input  logic [TAG_W-1:0] live_itags,
  input  logic [ACC_W-1:0] live_lma,
  output logic [ACC_W-1:0] acc_out,
  output logic             acc_valid,
  output logic [TAG_W-1:0] otags
);
  localparam logic [2:0] FN_NONE = 3'd0;
  localparam logic [2:0] RD_CNT  = 3'd1;
  localparam logic [2:0] RD_STA  = 3'd2;
  localparam logic [2:0] RD_TAG  = 3'd3;
  localparam logic [2:0] RD_LMA  = 3'd4;
  localparam logic [2:0] WR_CNT  = 3'd5;
  localparam logic [2:0] WR_DEV  = 3'd6;
  localparam logic [2:0] WR_OTG  = 3'd7;

  logic [ACC_W-1:0] hold_q;
  logic [2:0]       arm_q;
  logic [ACC_W-1:0] live_sel, wr_val;

  wire is_rd = fn_valid && (fn_code >= RD_CNT) && (fn_code <= RD_LMA);
  wire is_wr = fn_valid && (fn_code >= WR_CNT);
  wire hit   = is_rd && (arm_q == fn_code);

  always_comb begin
    case (fn_code)
      RD_CNT:  live_sel = ACC_W'(live_count);
      RD_STA:  live_sel = ACC_W'({live_addr, live_status});
      RD_TAG:  live_sel = ACC_W'(live_itags);
      default: live_sel = live_lma;
    endcase
  end

  always_comb begin
    case (fn_code)
      WR_CNT:  wr_val = ACC_W'(acc_in[CNT_W-1:0]);
      WR_OTG:  wr_val = ACC_W'(acc_in[TAG_W-1:0]);
      default: wr_val = acc_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      arm_q     <= FN_NONE;
      acc_out   <= '0;
      acc_valid <= 1'b0;
      otags     <= '0;
    end else begin
      acc_valid <= hit;
      if (hit) begin
        acc_out <= hold_q;
        arm_q   <= FN_NONE;
      end else if (is_rd) begin
        hold_q <= live_sel;
        arm_q  <= fn_code;
      end else if (is_wr) begin
        hold_q <= wr_val;
        arm_q  <= fn_code - 3'd4;
        if (fn_code == WR_OTG) otags <= acc_in[TAG_W-1:0];
      end else begin
        arm_q <= FN_NONE;
      end
    end
  end

  // R2: a back-to-back pair delivers the held value
  a_r2_pair_delivers: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && arm_q == fn_code) |=> (acc_valid && acc_out == $past(hold_q)));

  // R7: an unpaired read only captures
  a_r7_first_issue_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && arm_q != fn_code) |=> (!acc_valid && $stable(acc_out)));

  a_r6_gap_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (!fn_valid || fn_code == FN_NONE) |=> (arm_q == FN_NONE && !acc_valid));

  a_r12_otags_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(fn_valid && fn_code == WR_OTG) |=> $stable(otags));

  a_r8_no_double_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> !$past(acc_valid));

  a_r11_otags_load: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_valid && fn_code == WR_OTG) |=> (otags == $past(acc_in[TAG_W-1:0])));
endmodule

// File: tb/staged_readback_tb.sv
`timescale 1ns/1ps
module staged_readback_tb;
  localparam int TW = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fn_valid = 1'b0;
  logic [2:0] fn_code = 3'd0;
  logic [15:0] acc_in = '0;
  logic [15:0] live_count = '0;
  logic [7:0]  live_status = '0, live_addr = '0;
  logic [TW-1:0] live_itags = '0;
  logic [15:0] live_lma = '0;
  logic [15:0] acc_out;
  logic acc_valid;
  logic [TW-1:0] otags;
  int checks = 0, failures = 0;
  logic [15:0] exp_acc = '0;
  logic [TW-1:0] exp_ot = '0;

  always #2.5 clk = ~clk;

  staged_readback #(.TAG_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fn_valid(fn_valid), .fn_code(fn_code), .acc_in(acc_in),
    .live_count(live_count), .live_status(live_status), .live_addr(live_addr),
    .live_itags(live_itags), .live_lma(live_lma),
    .acc_out(acc_out), .acc_valid(acc_valid), .otags(otags));

  function automatic logic [15:0] live_of(input int r, input int s);
    logic [15:0] c = 16'(s * 16'h03B1 + 16'h00F0);
    logic [7:0] st = 8'(s * 8'h1D + 3);
    logic [7:0] ad = 8'(s * 8'h47) ^ 8'h5A;
    logic [TW-1:0] tg = TW'(s * 10'h13D + 7);
    logic [15:0] lm = 16'(s * 16'h91E3) ^ 16'hC33C;
    case (r)
      1: return c;
      2: return {ad, st};
      3: return 16'(tg);
      default: return lm;
    endcase
  endfunction

  task automatic set_live(input int s);
    logic [15:0] st = live_of(2, s);
    live_count = live_of(1, s);
    live_status = st[7:0];
    live_addr = st[15:8];
    live_itags = TW'(live_of(3, s));
    live_lma = live_of(4, s);
  endtask

  task automatic issue(input logic v, input int c, input logic [15:0] a);
    fn_valid = v;
    fn_code = 3'(c);
    acc_in = a;
    @(negedge clk);
    fn_valid = 1'b0;
    fn_code = 3'd0;
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic v);
    check(req, "acc_valid", 32'(acc_valid), 32'(v));
    check(req, "acc_out", 32'(acc_out), 32'(exp_acc));
    check(req, "otags", 32'(otags), 32'(exp_ot));
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_out("R1", 1'b0);

    // sweep every preceding function against every read
    for (int f1 = 0; f1 < 8; f1++) begin
      for (int f2 = 1; f2 < 5; f2++) begin
        logic [15:0] a = 16'(f1 * 16'h2F1B + f2 * 16'h0A57 + 16'h8001);
        logic dv;
        string tag;
        issue(1'b0, 0, '0);
        set_live(f1 * 4 + f2);
        issue(1'b1, f1, a);
        if (f1 == 7) exp_ot = a[TW-1:0];
        set_live(f1 * 4 + f2 + 77);
        issue(1'b1, f2, 16'hFFFF);
        dv = 1'b0;
        if (f1 == f2) begin
          dv = 1'b1;
          exp_acc = live_of(f2, f1 * 4 + f2);
        end else if (f1 == f2 + 4) begin
          dv = 1'b1;
          exp_acc = (f1 == 5) ? a : (f1 == 6) ? a : 16'(a[TW-1:0]);
        end
        if (f1 == f2) tag = (f2 == 1) ? "R2" : (f2 == 2) ? "R3" : (f2 == 3) ? "R4" : "R5";
        else if (f1 == f2 + 4) tag = (f1 == 5) ? "R9" : (f1 == 6) ? "R10" : "R11";
        else if (f1 >= 1 && f1 <= 4) tag = "R7";
        else if (f1 >= 5) tag = "R13";
        else tag = "R6";
        check_out(tag, dv);
        if (!dv) check_out("R12", 1'b0);
      end
    end

    // R8: four consecutive issues form two pairs
    issue(1'b0, 0, '0);
    set_live(501); issue(1'b1, 1, '0);
    set_live(502); issue(1'b1, 1, '0);
    exp_acc = live_of(1, 501);
    check_out("R8", 1'b1);
    set_live(503); issue(1'b1, 1, '0);
    check_out("R8", 1'b0);
    set_live(504); issue(1'b1, 1, '0);
    exp_acc = live_of(1, 503);
    check_out("R8", 1'b1);

    // R6: a gap cycle between two reads breaks the pair
    issue(1'b0, 0, '0);
    set_live(601); issue(1'b1, 4, '0);
    issue(1'b0, 4, '0);
    set_live(602); issue(1'b1, 4, '0);
    check_out("R6", 1'b0);
    issue(1'b1, 4, '0);
    exp_acc = live_of(4, 602);
    check_out("R6", 1'b1);

    // R1: reset clears everything again
    rst_n = 1'b0;
    @(negedge clk);
    exp_acc = '0; exp_ot = '0;
    check_out("R1", 1'b0);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule